// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block shapes the clock line of an I2C controller. A single timing word sets a power-of-two base tick and two independent phase lengths, one for the low half of each SCL period and one for the high half. While enabled, the generator alternates between a low phase, in which it asks the pad to pull SCL down, and a high phase, in which it releases the line and counts only once the line is actually seen high. This lets a slow target stretch the clock.

Three single-cycle strobes go to the bit engine. The fall strobe marks the first cycle of every low phase, so SDA may change there. The rise strobe marks the first cycle in which the released line reads high. The mid strobe marks the middle of the high phase, where SDA is sampled. The timing word is latched only when the generator leaves idle. Dropping the enable returns the block to idle at once, releases the line and clears every counter.

Top module: `scl_phase_gen`

## Requirements
- R1: With base exponent e and low count l, each low phase holds `scl_drive_low` high for exactly (l+1)·2^e clock cycles, starting with the cycle that carries `scl_fall_stb`.
- R2: With high count h, the high phase lasts exactly (h+1)·2^e cycles, counted from the `scl_rise_stb` cycle up to, but not including, the next `scl_fall_stb` cycle.
- R3: The timing word is decoded with the high count in bits 19:16, the low count in bits 15:12 and the base exponent in bits 3:0. All other bits have no effect on timing.
- R4: All counts are zero-based. With h = l = e = 0 and no stretching, the SCL period is exactly 2 cycles.
- R5: After the line is released, high-phase counting and `scl_rise_stb` wait until `scl_sense` reads 1. A stretch of S cycles lengthens the period by exactly S cycles.
- R6: `scl_mid_stb` pulses exactly once per high phase, ((h+1)>>1)·2^e cycles after the `scl_rise_stb` cycle. This is the same cycle as the rise strobe when h is 0.
- R7: One cycle after `en` is seen low, `scl_drive_low` and all strobes are 0. A later re-enable starts a full-length period from cleared counters.
- R8: The timing word is captured only on the transition from idle to running. Changes while running do not alter the period.
- R9: During reset `scl_drive_low` and all three strobes are 0.
- R10: `scl_rise_stb` and `scl_fall_stb` never assert in the same cycle, and `scl_fall_stb` appears only while the line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request; low forces idle |
| timing_word | input | WORD_W | Packed high count, low count and base exponent |
| scl_sense | input | 1 | Sampled SCL level (1 = high) |
| scl_drive_low | output | 1 | Request to pull SCL low |
| scl_rise_stb | output | 1 | First cycle SCL is seen high in a period |
| scl_fall_stb | output | 1 | First cycle of each low phase |
| scl_mid_stb | output | 1 | Middle of the high phase, for SDA sampling |

## Verification
The rise strobe and the mid strobe can land in the same cycle when the high count is zero. The end of a clock stretch can also coincide with the start of high-phase counting. Both cases are provoked by directed configurations with h = 0 and by random stretch lengths on the sense line. For each, the bench measures the offset of the mid strobe from the rise strobe and checks that the mid strobe appears exactly once per high phase. Phase lengths are measured in cycles and compared with values computed from the field values and the stretch length.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 4,
  parameter int EXP_W   = 4,
  parameter int HI_LSB  = 16,
  parameter int LO_LSB  = 12,
  parameter int EXP_LSB = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  hi_cnt,
  output logic [CNT_W-1:0]  lo_cnt,
  output logic [EXP_W-1:0]  exp_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      exp_sel <= '0;
    end else if (load) begin
      hi_cnt  <= word[HI_LSB +: CNT_W];
      lo_cnt  <= word[LO_LSB +: CNT_W];
      exp_sel <= word[EXP_LSB +: EXP_W];
    end
  end
endmodule

// File: rtl/scl_base_tick.sv
module scl_base_tick #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             last,
  output logic             at_zero
);
  localparam int PRE_W = (1 << EXP_W) - 1;
  localparam logic [PRE_W-1:0] P_ONE = PRE_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;

  always_comb begin
    span = ({{PRE_W{1'b0}}, 1'b1} << exp_sel) - {{PRE_W{1'b0}}, 1'b1};
    mask = span[PRE_W-1:0];
  end

  assign last    = (pre_q == mask);
  assign at_zero = (pre_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr)       pre_q <= '0;
    else if (run && last) pre_q <= '0;
    else if (run)         pre_q <= pre_q + P_ONE;
  end

  // R1: the prescaler never runs past the selected power-of-two span
  a_r1_pre_bound: assert property (@(posedge clk) disable iff (rst)
    (pre_q <= mask));
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_tg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             scl_sense,
  input  logic             last,
  input  logic             pre_zero,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             load_cfg,
  output logic             pre_clr,
  output logic             pre_run,
  output logic             drive_low,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             mid_stb,
  output phase_e           phase
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  phase_e           st_q;
  logic [CNT_W-1:0] tcnt_q;
  logic             hi_run_q;
  logic             drive_q;
  logic             running_hi;
  logic             cnt_en;
  logic             phase_end;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   hi_p1;
  logic [CNT_W-1:0] mid_pt;

  always_comb begin
    hi_p1      = {1'b0, hi_cnt} + {{CNT_W{1'b0}}, 1'b1};
    mid_pt     = hi_p1[CNT_W:1];
    running_hi = hi_run_q | scl_sense;
    cnt_en     = (st_q == PH_LOW) | ((st_q == PH_HIGH) & running_hi);
    lim        = (st_q == PH_LOW) ? lo_cnt : hi_cnt;
    phase_end  = cnt_en & last & (tcnt_q == lim);
  end

  assign load_cfg  = en & (st_q == PH_IDLE);
  assign pre_clr   = ~en | (st_q == PH_IDLE) | phase_end;
  assign pre_run   = cnt_en;
  assign drive_low = drive_q;
  assign phase     = st_q;
  assign fall_stb  = (st_q == PH_LOW) & pre_zero & (tcnt_q == '0);
  assign rise_stb  = (st_q == PH_HIGH) & ~hi_run_q & scl_sense;
  assign mid_stb   = (st_q == PH_HIGH) & running_hi & pre_zero & (tcnt_q == mid_pt);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q     <= PH_IDLE;
      tcnt_q   <= '0;
      hi_run_q <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          st_q     <= PH_LOW;
          drive_q  <= 1'b1;
          tcnt_q   <= '0;
          hi_run_q <= 1'b0;
        end
        PH_LOW: begin
          if (phase_end) begin
            st_q     <= PH_HIGH;
            drive_q  <= 1'b0;
            tcnt_q   <= '0;
            hi_run_q <= 1'b0;
          end else if (last) begin
            tcnt_q <= tcnt_q + C_ONE;
          end
        end
        PH_HIGH: begin
          if (running_hi) hi_run_q <= 1'b1;
          if (phase_end) begin
            st_q     <= PH_LOW;
            drive_q  <= 1'b1;
            tcnt_q   <= '0;
            hi_run_q <= 1'b0;
          end else if (cnt_en && last) begin
            tcnt_q <= tcnt_q + C_ONE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  // R7: a low enable releases the line on the next cycle
  a_r7_idle_release: assert property (@(posedge clk) disable iff (rst)
    !en |=> !drive_low);
  // R10: the fall strobe only while the line is pulled down
  a_r10_fall_driven: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> drive_q);
  // R10: rise and fall strobes are exclusive
  a_r10_edges_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_stb, fall_stb}));
  // R5: rise strobe only on a released line that reads high
  a_r5_rise_released: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (!drive_q && scl_sense));
  // R5: while stretched, the high-phase count stays frozen
  a_r5_stretch_freeze: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_HIGH && !hi_run_q && !scl_sense) |=> (tcnt_q == '0));
  // R6: mid strobe only inside the released high phase
  a_r6_mid_high: assert property (@(posedge clk) disable iff (rst)
    mid_stb |-> (!drive_q && st_q == PH_HIGH));
  // R1: low-phase tick count never passes the programmed limit
  a_r1_low_bound: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_LOW) |-> (tcnt_q <= lo_cnt));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_tg_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 4,
  parameter int EXP_W   = 4,
  parameter int HI_LSB  = 16,
  parameter int LO_LSB  = 12,
  parameter int EXP_LSB = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              scl_sense,
  output logic              scl_drive_low,
  output logic              scl_rise_stb,
  output logic              scl_fall_stb,
  output logic              scl_mid_stb
);
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] lo_cnt;
  logic [EXP_W-1:0] exp_sel;
  logic             load_cfg;
  logic             pre_clr;
  logic             pre_run;
  logic             last;
  logic             pre_zero;
  phase_e           phase;

  scl_cfg_latch #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .EXP_W(EXP_W),
    .HI_LSB(HI_LSB), .LO_LSB(LO_LSB), .EXP_LSB(EXP_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(load_cfg), .word(timing_word),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .exp_sel(exp_sel)
  );

  scl_base_tick #(.EXP_W(EXP_W)) u_tick (
    .clk(clk), .rst(rst), .clr(pre_clr), .run(pre_run),
    .exp_sel(exp_sel), .last(last), .at_zero(pre_zero)
  );

  scl_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .scl_sense(scl_sense),
    .last(last), .pre_zero(pre_zero), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .load_cfg(load_cfg), .pre_clr(pre_clr), .pre_run(pre_run),
    .drive_low(scl_drive_low), .rise_stb(scl_rise_stb),
    .fall_stb(scl_fall_stb), .mid_stb(scl_mid_stb), .phase(phase)
  );

  // R8: captured timing stays fixed while the generator keeps running
  a_r8_word_held: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable({hi_cnt, lo_cnt, exp_sel}));
endmodule

// File: tb/sim_scl_phase_gen.sv
`timescale 1ns/1ps
module sim_scl_phase_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] timing_word = '0;
  logic        hold_low = 1'b0;
  logic        scl_sense;
  logic        scl_drive_low, scl_rise_stb, scl_fall_stb, scl_mid_stb;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  // open-drain line: low when the generator or a stretching target pulls it
  assign scl_sense = !(scl_drive_low | hold_low);

  scl_phase_gen u0 (
    .clk(clk), .rst(rst), .en(en), .timing_word(timing_word),
    .scl_sense(scl_sense), .scl_drive_low(scl_drive_low),
    .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb),
    .scl_mid_stb(scl_mid_stb)
  );

  function automatic logic [31:0] pack(int h, int l, int e, logic [31:0] junk);
    logic [31:0] w;
    w = junk & ~32'h000F_F00F;
    w[19:16] = h[3:0];
    w[15:12] = l[3:0];
    w[3:0]   = e[3:0];
    return w;
  endfunction

  function automatic int exp_low(int l, int e);
    return (l + 1) << e;
  endfunction
  function automatic int exp_high(int h, int e);
    return (h + 1) << e;
  endfunction
  function automatic int exp_mid(int h, int e);
    return ((h + 1) >> 1) << e;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic start_gen(logic [31:0] w);
    @(negedge clk);
    en = 1'b0;
    timing_word = w;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic run_period(int h, int l, int e, int s, output int total);
    int guard, lo, k, mids, mid_at, bad;
    guard = 0;
    while (!scl_fall_stb && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    hold_low = (s > 0);
    lo = 0;
    do begin
      lo++;
      @(negedge clk);
    end while (scl_drive_low && lo < 5000);
    chk(lo == exp_low(l, e), "R1 low phase length", lo, exp_low(l, e));
    if (s > 0) begin
      bad = 0;
      for (int i = 0; i < s; i++) begin
        if (scl_rise_stb || scl_drive_low || scl_mid_stb) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R5 quiet while target stretches", bad, 0);
      hold_low = 1'b0;
      #1;
    end
    chk(scl_rise_stb == 1'b1, "R5 rise strobe when line reads high", int'(scl_rise_stb), 1);
    k = 0; mids = 0; mid_at = -1;
    while (!scl_fall_stb && k < 5000) begin
      if (scl_mid_stb) begin
        mids++;
        mid_at = k;
      end
      k++;
      @(negedge clk);
    end
    chk(k == exp_high(h, e), "R2 high phase length", k, exp_high(h, e));
    chk(mids == 1, "R6 one mid strobe per high phase", mids, 1);
    chk(mid_at == exp_mid(h, e), "R6 mid strobe offset", mid_at, exp_mid(h, e));
    total = lo + s + k;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t, h, l, e, s;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9: quiet outputs in reset
    chk(!scl_drive_low && !scl_rise_stb && !scl_fall_stb && !scl_mid_stb,
        "R9 reset state", int'({scl_drive_low, scl_rise_stb, scl_fall_stb, scl_mid_stb}), 0);
    rst = 1'b0;

    // R4: shortest period, rise and mid strobes share a cycle
    start_gen(pack(0, 0, 0, 32'h0));
    run_period(0, 0, 0, 0, t);
    chk(t == 2, "R4 shortest period", t, 2);
    run_period(0, 0, 0, 0, t);
    chk(t == 2, "R4 shortest period repeat", t, 2);
    run_period(0, 0, 0, 2, t);
    chk(t == 4, "R5 stretch adds cycles", t, 4);

    // R3: all non-field bits set
    start_gen(pack(15, 15, 2, 32'hFFFF_FFFF));
    run_period(15, 15, 2, 0, t);
    chk(t == 128, "R3 fields decoded, other bits ignored", t, 128);

    // recommended counts
    start_gen(pack(8, 7, 1, 32'h0));
    run_period(8, 7, 1, 0, t);
    chk(t == 34, "R1 recommended period", t, 34);

    // R8: rewrite the word while running
    start_gen(pack(3, 5, 1, 32'h0));
    run_period(3, 5, 1, 0, t);
    timing_word = pack(15, 15, 3, 32'h0);
    run_period(3, 5, 1, 0, t);
    chk(t == 20, "R8 running word change ignored", t, 20);

    // R7: drop enable in the low phase and in the high phase
    for (int off = 3; off <= 40; off += 37) begin
      int bad;
      start_gen(pack(6, 6, 2, 32'h0));
      run_period(6, 6, 2, 0, t);
      repeat (off) @(negedge clk);
      en = 1'b0;
      bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (scl_drive_low || scl_rise_stb || scl_fall_stb || scl_mid_stb) bad++;
      end
      chk(bad == 0, "R7 idle after enable drop", bad, 0);
      en = 1'b1;
      run_period(6, 6, 2, 0, t);
      chk(t == 56, "R7 full period after re-enable", t, 56);
    end

    // random configurations with stretching and junk bits
    for (int n = 0; n < 40; n++) begin
      h = int'($urandom % 16);
      l = int'($urandom % 16);
      e = int'($urandom % 4);
      s = int'($urandom % 4);
      start_gen(pack(h, l, e, $urandom));
      run_period(h, l, e, s, t);
      chk(t == exp_low(l, e) + exp_high(h, e) + s, "R1 random period", t,
          exp_low(l, e) + exp_high(h, e) + s);
      timing_word = $urandom;
      run_period(h, l, e, 0, t);
      chk(t == exp_low(l, e) + exp_high(h, e), "R8 random period after word change", t,
          exp_low(l, e) + exp_high(h, e));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule